// File: doc/BRIEF.md
# Slot-Time Transfer Pacer

This block paces a stream of bus transfers. Each command carries a slot length in microseconds. The block keeps a signed time balance that measures how much of the reserved slot time is still owed. A grant reserves the slot of the command it starts. Each microsecond tick then pays one unit back. A transfer that finishes early is held off until the owed time has run out. A transfer that overruns drives the balance negative, and following commands start without a pause until the deficit is repaid. The balance may stay negative across any number of commands.

A command may be flagged as waiting for an external sync event. The sync input passes through a synchronizer and an edge detector. A rising edge sets a latch that remains set until a flagged command uses it. Software can also set or clear the latch. When a flagged command starts, the balance is replaced by that command's slot, so the schedule timer restarts from the sync event. Suspending the schedule blocks grants, but the balance keeps counting and the latch keeps its value. Stopping the schedule clears the balance, the latch and the in-flight flag.

Top module: `slot_pacer`

## Requirements
- R1: After reset, `start_ok` is 0, `balance` is 0 and the schedule is idle: no grant is issued until `cmd_start`.
- R2: A grant takes place at a clock edge and shows on `start_ok` one cycle later. At that edge the balance becomes old balance + `slot_time` − `tick_us`. Without `need_sync`, the next grant needs the balance to be ≤ 0 at the edge, so an early finish waits out the rest of the slot.
- R3: A transfer that runs past its slot drives the balance negative. The next command is granted on the first edge after `xfer_done` in which the other conditions hold, and its slot is added to the negative balance, so the deficit carries over several commands.
- R4: The balance is two's complement of width BAL_W (default 22, more than one second of 1 µs ticks). It saturates at −2^(BAL_W−1) and never wraps to a positive value.
- R5: `start_ok` is a one-cycle pulse. It is issued only while running, with `gap_done` high and no transfer in flight, and never in a cycle that carries `cmd_stop` or `cmd_suspend`. A transfer is in flight from its grant until `xfer_done`.
- R6: With a slot of 0, a new grant follows `xfer_done` on the next edge, so `start_ok` pulses two cycles apart.
- R7: `cmd_suspend` (while running) blocks grants, but ticks still decrement the balance. `cmd_resume` returns to running.
- R8: `cmd_stop` has priority over every other input. It sets the balance to 0, clears the sync latch and the in-flight flag, and leaves the schedule idle until `cmd_start`.
- R9: While `need_sync` is 1, the grant waits for the sync latch and ignores the balance. The flagged grant sets the balance to exactly `slot_time` and consumes the latch.
- R10: `sync_in` passes through two flip-flops before edge detection. A one-cycle high pulse sets the latch at the third edge, and a pulse that arrives while a transfer is in flight is held until the flagged command is reached.
- R11: `trig_set` sets the latch and `trig_clr` clears it. A clear wins over a set or a sync edge in the same cycle. A new sync edge wins over a consumption in the same cycle.
- R12: The sync latch keeps its value through suspend and resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle 1 µs time tick |
| slot_time | input | SLOT_W | Slot length of the next command, in µs |
| need_sync | input | 1 | Next command waits for an external sync event |
| xfer_done | input | 1 | Transfer in flight has ended |
| gap_done | input | 1 | Mandated intermessage gap has elapsed |
| cmd_start | input | 1 | Start the schedule from idle |
| cmd_stop | input | 1 | Stop and clear the schedule |
| cmd_suspend | input | 1 | Suspend a running schedule |
| cmd_resume | input | 1 | Resume a suspended schedule |
| sync_in | input | 1 | Asynchronous external sync |
| trig_set | input | 1 | Software set of the sync latch |
| trig_clr | input | 1 | Software clear of the sync latch |
| start_ok | output | 1 | Start-permitted pulse |
| balance | output | BAL_W | Signed time balance (owed µs) |

## Verification
A flagged grant consuming the sync latch can land in the same cycle as a fresh synchronized sync edge, and the edge must leave the latch set for the next flagged command. In the same way, a software set and clear can coincide, and so can a suspend and a grant that would otherwise fire. Random stimulus toggles `sync_in`, the software trigger lines and the suspend command while commands with and without the sync flag are granted. A cycle-level reference model in the bench predicts `start_ok` and `balance` in every cycle and judges these overlaps. Directed cases force the clear-over-set collision and a sync pulse that arrives while a transfer is in flight.

// File: rtl/slot_pacer_pkg.sv
package slot_pacer_pkg;
   typedef enum logic [1:0] {
      SP_IDLE = 2'd0,
      SP_RUN  = 2'd1,
      SP_HOLD = 2'd2
   } sp_state_e;
endpackage

// File: rtl/sp_sync_edge.sv
module sp_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   logic [STAGES-1:0] sh;
   logic              last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh[0] <= 1'b0;
      else        sh[0] <= din;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh[i] <= 1'b0;
         else        sh[i] <= sh[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last <= 1'b0;
      else        last <= sh[STAGES-1];
   end

   assign rise = sh[STAGES-1] & ~last;
endmodule

// File: rtl/sp_balance.sv
module sp_balance #(
   parameter int BAL_W  = 22,
   parameter int SLOT_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clear,
   input  logic                     grant,
   input  logic                     sync_load,
   input  logic                     tick,
   input  logic [SLOT_W-1:0]        slot_time,
   output logic signed [BAL_W-1:0]  balance,
   output logic                     ready
);
   localparam int WW = BAL_W + 1;
   localparam logic signed [BAL_W-1:0] MAXV = {1'b0, {(BAL_W-1){1'b1}}};
   localparam logic signed [BAL_W-1:0] MINV = {1'b1, {(BAL_W-1){1'b0}}};
   localparam logic signed [WW-1:0]    MAXW = {2'b00, {(BAL_W-1){1'b1}}};
   localparam logic signed [WW-1:0]    MINW = {2'b11, {(BAL_W-1){1'b0}}};

   logic signed [WW-1:0]    slot_add;
   logic signed [WW-1:0]    tick_sub;
   logic signed [WW-1:0]    wide;
   logic signed [BAL_W-1:0] nxt;

   always_comb begin
      slot_add = grant ? $signed({{(WW-SLOT_W){1'b0}}, slot_time}) : '0;
      tick_sub = tick  ? $signed({{(WW-1){1'b0}}, 1'b1}) : '0;
      wide     = $signed({balance[BAL_W-1], balance}) + slot_add - tick_sub;
      if (clear)
         nxt = '0;
      else if (sync_load)
         nxt = $signed({{(BAL_W-SLOT_W){1'b0}}, slot_time});
      else if (wide > MAXW)
         nxt = MAXV;
      else if (wide < MINW)
         nxt = MINV;
      else
         nxt = wide[BAL_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) balance <= '0;
      else        balance <= nxt;
   end

   assign ready = (balance <= 0);
endmodule

// File: rtl/sp_ctrl.sv
module sp_ctrl
   import slot_pacer_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cmd_start,
   input  logic      cmd_stop,
   input  logic      cmd_suspend,
   input  logic      cmd_resume,
   input  logic      gap_done,
   input  logic      need_sync,
   input  logic      xfer_done,
   input  logic      sync_rise,
   input  logic      trig_set,
   input  logic      trig_clr,
   input  logic      bal_ready,
   output sp_state_e state,
   output logic      grant,
   output logic      clear_bal,
   output logic      start_ok
);
   sp_state_e st_nxt;
   logic      busy;
   logic      latch;
   logic      time_ok;

   always_comb begin
      time_ok   = need_sync ? latch : bal_ready;
      grant     = (state == SP_RUN) && !busy && gap_done && !cmd_stop &&
                  !cmd_suspend && time_ok;
      clear_bal = cmd_stop || (state == SP_IDLE);
   end

   always_comb begin
      st_nxt = state;
      if (cmd_stop)                            st_nxt = SP_IDLE;
      else if (state == SP_IDLE && cmd_start)  st_nxt = SP_RUN;
      else if (state == SP_RUN && cmd_suspend) st_nxt = SP_HOLD;
      else if (state == SP_HOLD && cmd_resume) st_nxt = SP_RUN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SP_IDLE;
         busy     <= 1'b0;
         latch    <= 1'b0;
         start_ok <= 1'b0;
      end else begin
         state    <= st_nxt;
         start_ok <= grant;
         if (cmd_stop)       busy <= 1'b0;
         else if (grant)     busy <= 1'b1;
         else if (xfer_done) busy <= 1'b0;
         if (cmd_stop || trig_clr)           latch <= 1'b0;
         else if (trig_set || sync_rise)     latch <= 1'b1;
         else if (grant && need_sync)        latch <= 1'b0;
      end
   end
endmodule

// File: rtl/slot_pacer.sv
module slot_pacer
   import slot_pacer_pkg::*;
#(
   parameter int BAL_W       = 22,
   parameter int SLOT_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick_us,
   input  logic [SLOT_W-1:0]       slot_time,
   input  logic                    need_sync,
   input  logic                    xfer_done,
   input  logic                    gap_done,
   input  logic                    cmd_start,
   input  logic                    cmd_stop,
   input  logic                    cmd_suspend,
   input  logic                    cmd_resume,
   input  logic                    sync_in,
   input  logic                    trig_set,
   input  logic                    trig_clr,
   output logic                    start_ok,
   output logic signed [BAL_W-1:0] balance
);
   if (SLOT_W >= BAL_W) begin : g_bad_width
      $error("slot_pacer: SLOT_W must be narrower than BAL_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("slot_pacer: SYNC_STAGES must be at least 2");
   end

   sp_state_e st;
   logic      sync_rise;
   logic      grant;
   logic      clear_bal;
   logic      bal_ready;

   sp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (sync_in),
      .rise (sync_rise)
   );

   sp_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_start  (cmd_start),
      .cmd_stop   (cmd_stop),
      .cmd_suspend(cmd_suspend),
      .cmd_resume (cmd_resume),
      .gap_done   (gap_done),
      .need_sync  (need_sync),
      .xfer_done  (xfer_done),
      .sync_rise  (sync_rise),
      .trig_set   (trig_set),
      .trig_clr   (trig_clr),
      .bal_ready  (bal_ready),
      .state      (st),
      .grant      (grant),
      .clear_bal  (clear_bal),
      .start_ok   (start_ok)
   );

   sp_balance #(.BAL_W(BAL_W), .SLOT_W(SLOT_W)) u_bal (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clear_bal),
      .grant    (grant),
      .sync_load(grant && need_sync),
      .tick     (tick_us),
      .slot_time(slot_time),
      .balance  (balance),
      .ready    (bal_ready)
   );
endmodule

// File: rtl/sp_checker.sv
module sp_checker
   import slot_pacer_pkg::*;
#(
   parameter int BAL_W  = 22,
   parameter int SLOT_W = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    tick_us,
   input logic [SLOT_W-1:0]       slot_time,
   input logic                    need_sync,
   input logic                    gap_done,
   input logic                    cmd_stop,
   input logic                    start_ok,
   input logic signed [BAL_W-1:0] balance,
   input sp_state_e               st
);
   localparam logic signed [BAL_W-1:0] MINV = {1'b1, {(BAL_W-1){1'b0}}};

   AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      start_ok |=> !start_ok); // R5
   AST_GRANT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      start_ok |-> $past(gap_done)); // R5
   AST_HOLD_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) != SP_RUN) |-> !start_ok); // R7
   AST_HOLD_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) == SP_HOLD && !$past(cmd_stop) && $past(tick_us) && $past(balance) != MINV)
      |-> balance == $past(balance) - 1); // R7
   AST_STOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cmd_stop) |-> (balance == 0 && st == SP_IDLE)); // R8
   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !start_ok |-> !($past(balance) < 0 && balance > 0)); // R4
   AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (start_ok && $past(need_sync))
      |-> balance == $signed({{(BAL_W-SLOT_W){1'b0}}, $past(slot_time)})); // R9
endmodule

bind slot_pacer sp_checker #(.BAL_W(BAL_W), .SLOT_W(SLOT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick_us  (tick_us),
   .slot_time(slot_time),
   .need_sync(need_sync),
   .gap_done (gap_done),
   .cmd_stop (cmd_stop),
   .start_ok (start_ok),
   .balance  (balance),
   .st       (st)
);

// File: tb/sim_slot_pacer.sv
`timescale 1ns/1ps
module sim_slot_pacer;
   localparam int BW = 10;
   localparam int SW = 8;
   localparam int BMIN = -(1 << (BW-1));
   localparam int BMAX = (1 << (BW-1)) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_us = 1'b0;
   logic [SW-1:0] slot_time = '0;
   logic need_sync = 1'b0, xfer_done = 1'b0, gap_done = 1'b1;
   logic cmd_start = 1'b0, cmd_stop = 1'b0, cmd_suspend = 1'b0, cmd_resume = 1'b0;
   logic sync_in = 1'b0, trig_set = 1'b0, trig_clr = 1'b0;
   logic start_ok;
   logic signed [BW-1:0] balance;

   int errors = 0;
   int checks = 0;
   string req = "R1";

   always #2 clk = ~clk;

   slot_pacer #(.BAL_W(BW), .SLOT_W(SW), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .slot_time(slot_time),
      .need_sync(need_sync), .xfer_done(xfer_done), .gap_done(gap_done),
      .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_suspend(cmd_suspend),
      .cmd_resume(cmd_resume), .sync_in(sync_in), .trig_set(trig_set),
      .trig_clr(trig_clr), .start_ok(start_ok), .balance(balance)
   );

   // reference model: 0 idle, 1 running, 2 suspended
   int       m_st, m_bal;
   logic     m_busy, m_latch, m_ok;
   logic [2:0] m_s;

   function automatic int sat(int v);
      if (v < BMIN) return BMIN;
      if (v > BMAX) return BMAX;
      return v;
   endfunction

   always @(posedge clk or negedge rst_n) begin : model
      logic g, e;
      if (!rst_n) begin
         m_st <= 0; m_bal <= 0; m_busy <= 1'b0; m_latch <= 1'b0;
         m_ok <= 1'b0; m_s <= '0;
      end else begin
         g = (m_st == 1) && !m_busy && gap_done && !cmd_stop && !cmd_suspend &&
             (need_sync ? m_latch : (m_bal <= 0));
         e = m_s[1] & ~m_s[2];
         m_s <= {m_s[1], m_s[0], sync_in};
         m_ok <= g;
         if (cmd_stop) m_st <= 0;
         else if (m_st == 0 && cmd_start) m_st <= 1;
         else if (m_st == 1 && cmd_suspend) m_st <= 2;
         else if (m_st == 2 && cmd_resume) m_st <= 1;
         if (cmd_stop) m_busy <= 1'b0;
         else if (g) m_busy <= 1'b1;
         else if (xfer_done) m_busy <= 1'b0;
         if (cmd_stop || trig_clr) m_latch <= 1'b0;
         else if (trig_set || e) m_latch <= 1'b1;
         else if (g && need_sync) m_latch <= 1'b0;
         if (cmd_stop || m_st == 0) m_bal <= 0;
         else if (g && need_sync) m_bal <= int'(slot_time);
         else m_bal <= sat(m_bal + (g ? int'(slot_time) : 0) - (tick_us ? 1 : 0));
      end
   end

   task automatic chk(string r, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      chk({req, " start_ok"}, int'(start_ok), int'(m_ok));
      chk({req, " balance"}, int'(balance), m_bal);
   endtask

   task automatic wait_ok(output int n);
      n = 0;
      do begin step(); n++; end while (!start_ok && n < 2000);
   endtask

   task automatic pulse_done();
      xfer_done = 1'b1; step(); xfer_done = 1'b0;
   endtask

   task automatic restart();
      cmd_stop = 1'b1; step(); cmd_stop = 1'b0;
      cmd_start = 1'b1; step(); cmd_start = 1'b0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=expired expected=done");
      finish_run();
   end

   initial begin : main
      int n, oks;
      void'($urandom(32'd1553));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      chk("R1 reset start_ok", int'(start_ok), 0);
      chk("R1 reset balance", int'(balance), 0);
      repeat (3) step();
      chk("R1 idle no grant", int'(start_ok), 0);

      // R6: zero slot, back to back
      req = "R6"; tick_us = 1'b1; slot_time = 0;
      cmd_start = 1'b1; step(); cmd_start = 1'b0;
      wait_ok(n);
      for (int i = 0; i < 3; i++) begin
         pulse_done(); wait_ok(n);
         chk("R6 grant right after done", n, 1);
      end

      // R2: early finish waits out the slot
      req = "R2"; pulse_done(); restart(); slot_time = 20;
      wait_ok(n);
      chk("R2 balance after grant", int'(balance), 19);
      pulse_done(); wait_ok(n);
      chk("R2 wait for slot", n, 19);

      // R3: overrun borrowing chains
      req = "R3"; pulse_done(); restart(); slot_time = 5;
      wait_ok(n);
      repeat (30) step();
      pulse_done(); wait_ok(n);
      chk("R3 immediate grant", n, 1);
      chk("R3 balance after borrow", int'(balance), -23);
      pulse_done(); wait_ok(n);
      chk("R3 chained borrow", int'(balance), -20);

      // R4: saturation at negative limit
      req = "R4"; pulse_done(); restart(); slot_time = 0;
      wait_ok(n);
      repeat (600) step();
      chk("R4 saturated", int'(balance), BMIN);
      slot_time = 3;
      pulse_done(); wait_ok(n);
      chk("R4 no wrap", int'(balance), BMIN + 2);

      // R7: suspend keeps time
      req = "R7"; pulse_done(); restart(); slot_time = 50;
      wait_ok(n); pulse_done();
      cmd_suspend = 1'b1; step(); cmd_suspend = 1'b0;
      oks = 0;
      for (int i = 0; i < 30; i++) begin step(); oks += int'(start_ok); end
      chk("R7 balance in suspend", int'(balance), 17);
      chk("R7 no grant in suspend", oks, 0);
      cmd_resume = 1'b1; step(); cmd_resume = 1'b0;
      wait_ok(n);
      chk("R7 grant after resume", n, 17);

      // R9: sync wait overrides balance
      req = "R9"; pulse_done(); restart(); need_sync = 1'b1; slot_time = 7;
      oks = 0;
      for (int i = 0; i < 20; i++) begin step(); oks += int'(start_ok); end
      chk("R9 waits for sync", oks, 0);
      sync_in = 1'b1; step(); sync_in = 1'b0;
      n = 1; while (!start_ok && n < 50) begin step(); n++; end
      chk("R10 sync latency", n, 4);
      chk("R9 balance equals slot", int'(balance), 7);

      // R10: early edge latched while busy
      req = "R10";
      sync_in = 1'b1; step(); sync_in = 1'b0;
      repeat (6) step();
      pulse_done(); wait_ok(n);
      chk("R10 latched edge used", n, 1);

      // R11: software trigger
      req = "R11"; pulse_done();
      trig_set = 1'b1; step(); trig_set = 1'b0;
      wait_ok(n);
      chk("R11 set grants", n, 1);
      pulse_done();
      trig_set = 1'b1; trig_clr = 1'b1; step(); trig_set = 1'b0; trig_clr = 1'b0;
      oks = 0;
      for (int i = 0; i < 10; i++) begin step(); oks += int'(start_ok); end
      chk("R11 clear wins", oks, 0);

      // R12: latch kept through suspend
      req = "R12";
      cmd_suspend = 1'b1; step(); cmd_suspend = 1'b0;
      trig_set = 1'b1; step(); trig_set = 1'b0;
      repeat (5) step();
      cmd_resume = 1'b1; step(); cmd_resume = 1'b0;
      wait_ok(n);
      chk("R12 grant after resume", n, 1);

      // R8: stop clears latch and balance
      req = "R8"; pulse_done();
      trig_set = 1'b1; step(); trig_set = 1'b0;
      cmd_stop = 1'b1; cmd_start = 1'b1; step(); cmd_stop = 1'b0; cmd_start = 1'b0;
      chk("R8 balance zero", int'(balance), 0);
      cmd_start = 1'b1; step(); cmd_start = 1'b0;
      oks = 0;
      for (int i = 0; i < 10; i++) begin step(); oks += int'(start_ok); end
      chk("R8 latch cleared", oks, 0);

      // R5: constrained random, model checked every cycle
      req = "R5";
      for (int i = 0; i < 6000; i++) begin
         tick_us     = ($urandom % 2) == 0;
         gap_done    = ($urandom % 10) != 0;
         need_sync   = ($urandom % 8) == 0;
         slot_time   = SW'($urandom % 16);
         xfer_done   = ($urandom % 5) == 0;
         if (($urandom % 12) == 0) sync_in = ~sync_in;
         trig_set    = ($urandom % 60) == 0;
         trig_clr    = ($urandom % 90) == 0;
         cmd_suspend = ($urandom % 50) == 0;
         cmd_resume  = ($urandom % 15) == 0;
         cmd_stop    = ($urandom % 400) == 0;
         cmd_start   = ($urandom % 15) == 0;
         step();
      end
      finish_run();
   end
endmodule